// File: doc/BRIEF.md
# Variable Field-Width Packed Adder

This block adds two 128-bit registers as a row of independent lanes whose width is picked per operation: 2, 4, 8, 16, 32, 64 or 128 bits. The addition runs on a single ripple carry path. At every lane edge the carry is cut, so no lane affects the next, and each lane wraps modulo two to the power of its width.

Each operand first passes through its own half-lane selector. The selector can pass a lane as it is. It can also move the upper half of the lane down into the lower half and clear the upper half, or keep the lower half and clear the upper half. With these selectors, pairs of narrow values packed inside wider lanes can be added without separate mask and shift steps. The block is purely combinational from operands to sum.

Top module: `swar_adder`

## Requirements
- R1: Width code `width_sel` values 0 to 6 select lane widths 2, 4, 8, 16, 32, 64 and 128 bits. Codes 7 and above act as 128-bit lanes.
- R2: Every lane of `sum` equals the sum of the two selected operand lanes modulo 2^width. No carry crosses a lane edge, even when every bit of a lane is one.
- R3: Selector code 2'b00 passes the operand lane unchanged. Code 2'b11 behaves identically to 2'b00.
- R4: Selector code 2'b01 places the upper half of each lane into its lower half and forces the upper half to zero.
- R5: Selector code 2'b10 keeps the lower half of each lane and forces the upper half to zero.
- R6: The two operand selectors act independently. Any combination of codes on `sel_a` and `sel_b` gives the sum of the two separately selected operands.
- R7: The carry out of the top bit of each lane, including bit 127, is discarded. All-ones plus one at 128-bit width yields zero.
- R8: `sum` depends only on the present inputs, with no clock or stored state. Zero operands give a zero sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 128 | First operand |
| op_b | input | 128 | Second operand |
| width_sel | input | 3 | Lane width code: 0 = 2 bits, up to 6 = 128 bits |
| sel_a | input | 2 | Half-lane selector for op_a |
| sel_b | input | 2 | Half-lane selector for op_b |
| sum | output | 128 | Lane-wise wrapped sum |

## Verification
The hardest condition to reach from the ports is a carry that arrives at a lane edge. The carry must be generated in one lane and then propagate through a run of ones up to the top bit of that lane. Random operands rarely build such a run across a whole wide lane. To reach it, the stimulus pairs each random operand with an operand close to its complement. A repeating low-bit pattern is ORed in, so that long carry runs end exactly at lane edges for every width code. Code 7 is driven with a pattern that yields a different sum for each possible lane width, so aliasing to any width other than 128 bits is visible.

// File: rtl/swar_pkg.sv
package swar_pkg;

  typedef enum logic [1:0] {
    SEL_KEEP = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_PASS = 2'b11
  } half_sel_e;

  // log2 of lane width: code c selects 2^(c+1) bits, clamped to full register
  function automatic int lane_log2(input int code, input int max_log2);
    int r;
    r = code + 1;
    if (r > max_log2) r = max_log2;
    return r;
  endfunction

endpackage

// File: rtl/swar_width_decode.sv
module swar_width_decode #(
  parameter int DATA_W  = 128,
  parameter int CODE_W  = 3,
  parameter int LOG_W   = $clog2(DATA_W),
  parameter int LG_BITS = $clog2(LOG_W + 1)
) (
  input  logic [CODE_W-1:0]  width_sel,
  output logic [LG_BITS-1:0] lane_lg,
  output logic [DATA_W-1:0]  lane_end
);
  import swar_pkg::*;

  int lgi;

  always_comb begin
    lgi     = lane_log2(int'(width_sel), LOG_W);
    lane_lg = LG_BITS'(lgi);
    for (int i = 0; i < DATA_W; i++) begin
      lane_end[i] = (((i + 1) & ((1 << lgi) - 1)) == 0);
    end
  end

  always_comb begin
    // R1: number of lane edges matches the selected width
    a_r1_edge_count: assert ($countones(lane_end) == (DATA_W >> int'(lane_lg)));
    // R7: the top bit always closes a lane
    a_r7_top_edge: assert (lane_end[DATA_W-1]);
  end

endmodule

// File: rtl/swar_half_mod.sv
module swar_half_mod #(
  parameter int DATA_W  = 128,
  parameter int LOG_W   = $clog2(DATA_W),
  parameter int LG_BITS = $clog2(LOG_W + 1)
) (
  input  logic [DATA_W-1:0]  opnd,
  input  logic [LG_BITS-1:0] lane_lg,
  input  logic [1:0]         sel,
  output logic [DATA_W-1:0]  opnd_mod
);
  import swar_pkg::*;

  logic              want_keep, want_high, want_low;
  logic [DATA_W-1:0] acc [LOG_W+1];

  assign want_keep = (sel == SEL_KEEP) || (sel == SEL_PASS);
  assign want_high = (sel == SEL_HIGH);
  assign want_low  = (sel == SEL_LOW);

  assign acc[0] = opnd & {DATA_W{want_keep}};

  for (genvar k = 1; k <= LOG_W; k++) begin : g_lg
    localparam int LW   = 1 << k;
    localparam int HALF = LW / 2;
    localparam int NL   = DATA_W / LW;
    logic [DATA_W-1:0] hi_c, lo_c;
    logic              pick;
    assign pick = (int'(lane_lg) == k);
    for (genvar f = 0; f < NL; f++) begin : g_lane
      assign hi_c[f*LW +: HALF]        = opnd[f*LW + HALF +: HALF];
      assign hi_c[f*LW + HALF +: HALF] = '0;
      assign lo_c[f*LW +: HALF]        = opnd[f*LW +: HALF];
      assign lo_c[f*LW + HALF +: HALF] = '0;
    end
    assign acc[k] = acc[k-1]
                  | (hi_c & {DATA_W{pick & want_high}})
                  | (lo_c & {DATA_W{pick & want_low}});
  end

  assign opnd_mod = acc[LOG_W];

  function automatic logic [DATA_W-1:0] upper_mask(input int lg);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i >> (lg - 1)) & 1) == 1;
    return m;
  endfunction

  always_comb begin
    if (want_keep) begin
      a_r3_keep_equal: assert (opnd_mod == opnd);
    end
    if (want_high || want_low) begin
      a_r4_upper_zero: assert ((opnd_mod & upper_mask(int'(lane_lg))) == '0);
    end
    if (want_low) begin
      a_r5_lower_kept: assert (((opnd_mod ^ opnd) & ~upper_mask(int'(lane_lg))) == '0);
    end
  end

endmodule

// File: rtl/swar_carry_chain.sv
module swar_carry_chain #(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] lane_end,
  output logic [DATA_W-1:0] sum
);
  logic c, cout;

  always_comb begin
    c    = 1'b0;
    cout = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      sum[i] = a[i] ^ b[i] ^ c;
      cout   = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
      c      = lane_end[i] ? 1'b0 : cout;
    end
  end

  always_comb begin
    // R2: bit 0 never sees a carry
    a_r2_first_bit: assert (sum[0] == (a[0] ^ b[0]));
    // R2: the bit just above each lane edge starts with no carry
    for (int i = 0; i < DATA_W - 1; i++) begin
      if (lane_end[i]) begin
        a_r2_lane_isolation: assert (sum[i+1] == (a[i+1] ^ b[i+1]));
      end
    end
  end

endmodule

// File: rtl/swar_adder.sv
module swar_adder #(
  parameter int DATA_W = 128,
  parameter int CODE_W = 3
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [CODE_W-1:0] width_sel,
  input  logic [1:0]        sel_a,
  input  logic [1:0]        sel_b,
  output logic [DATA_W-1:0] sum
);
  localparam int LOG_W   = $clog2(DATA_W);
  localparam int LG_BITS = $clog2(LOG_W + 1);

  logic [LG_BITS-1:0] lane_lg;
  logic [DATA_W-1:0]  lane_end;
  logic [DATA_W-1:0]  a_mod, b_mod;

  swar_width_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W), .LOG_W(LOG_W), .LG_BITS(LG_BITS)) u_dec (
    .width_sel (width_sel),
    .lane_lg   (lane_lg),
    .lane_end  (lane_end)
  );

  swar_half_mod #(.DATA_W(DATA_W), .LOG_W(LOG_W), .LG_BITS(LG_BITS)) u_mod_a (
    .opnd     (op_a),
    .lane_lg  (lane_lg),
    .sel      (sel_a),
    .opnd_mod (a_mod)
  );

  swar_half_mod #(.DATA_W(DATA_W), .LOG_W(LOG_W), .LG_BITS(LG_BITS)) u_mod_b (
    .opnd     (op_b),
    .lane_lg  (lane_lg),
    .sel      (sel_b),
    .opnd_mod (b_mod)
  );

  swar_carry_chain #(.DATA_W(DATA_W)) u_chain (
    .a        (a_mod),
    .b        (b_mod),
    .lane_end (lane_end),
    .sum      (sum)
  );

  always_comb begin
    // R7: one full-width lane is a plain wrapped addition
    if (int'(lane_lg) == LOG_W) begin
      a_r7_full_wrap: assert (sum == a_mod + b_mod);
    end
  end

endmodule

// File: tb/sim_swar_adder.sv
module sim_swar_adder;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] op_a = '0, op_b = '0;
  logic [2:0]   width_sel = '0;
  logic [1:0]   sel_a = '0, sel_b = '0;
  logic [127:0] sum;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  swar_adder u0 (
    .op_a(op_a), .op_b(op_b), .width_sel(width_sel),
    .sel_a(sel_a), .sel_b(sel_b), .sum(sum)
  );

  localparam int NV = 9;
  localparam logic [2:0]   VW [NV] = '{3'd2, 3'd0, 3'd6, 3'd1, 3'd2, 3'd7, 3'd2, 3'd2, 3'd2};
  localparam logic [1:0]   VSA[NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [1:0]   VSB[NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0};
  localparam logic [127:0] VA [NV] = '{
    {128{1'b1}}, {32{4'h5}}, {128{1'b1}}, {16{8'h0F}}, {16{8'h0F}},
    {2{64'hFFFF_FFFF_FFFF_FFFF}}, {16{8'hA5}}, {16{8'hA5}}, {16{8'hA5}}};
  localparam logic [127:0] VB [NV] = '{
    {16{8'h01}}, {32{4'h5}}, 128'd1, {16{8'h01}}, {16{8'h01}},
    128'd1, 128'd0, {16{8'h3C}}, 128'd0};
  localparam logic [127:0] VE [NV] = '{
    128'd0, {32{4'hA}}, 128'd0, 128'd0, {16{8'h10}},
    128'd0, {16{8'h0A}}, {16{8'h11}}, {16{8'hA5}}};
  localparam string VT [NV] = '{"R2", "R2", "R7", "R2", "R1", "R1", "R4", "R5", "R3"};

  function automatic logic [127:0] ref_sum(input logic [127:0] a, input logic [127:0] b,
                                            input int code, input int sa, input int sb);
    int w, h;
    logic [127:0] m, hm, fa, fb, r;
    w  = (code >= 6) ? 128 : (2 << code);
    h  = w / 2;
    m  = (128'd1 << w) - 128'd1;
    hm = (128'd1 << h) - 128'd1;
    r  = '0;
    for (int f = 0; f < 128 / w; f++) begin
      fa = (a >> (f * w)) & m;
      fb = (b >> (f * w)) & m;
      if (sa == 1) fa = fa >> h; else if (sa == 2) fa = fa & hm;
      if (sb == 1) fb = fb >> h; else if (sb == 2) fb = fb & hm;
      r = r | (((fa + fb) & m) << (f * w));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] exp);
    checks++;
    if (sum !== exp) begin
      fails++;
      $display("FAIL %s w=%0d sa=%0d sb=%0d actual=%h expected=%h",
               tag, width_sel, sel_a, sel_b, sum, exp);
    end
  endtask

  task automatic apply(input logic [127:0] a, input logic [127:0] b,
                       input logic [2:0] w, input logic [1:0] sa, input logic [1:0] sb);
    @(negedge clk);
    op_a = a; op_b = b; width_sel = w; sel_a = sa; sel_b = sb;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0]  s;
    logic [127:0] ra, rb;
    s = 64'h9E37_79B9_7F4A_7C15;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset zero", 128'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(VA[v], VB[v], VW[v], VSA[v], VSB[v]);
      check(VT[v], VE[v]);
    end

    for (int w = 0; w < 8; w++) begin
      for (int sa = 0; sa < 4; sa++) begin
        for (int sb = 0; sb < 4; sb++) begin
          for (int rep = 0; rep < 2; rep++) begin
            s  = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            ra[63:0] = s;
            s  = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            ra[127:64] = s;
            if (rep == 0) rb = ~ra | {64{2'b01}};
            else begin
              s  = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
              rb = {s, ~s};
            end
            apply(ra, rb, 3'(w), 2'(sa), 2'(sb));
            check("R6 R2 R3 R4 R5 sweep", ref_sum(ra, rb, w, sa, sb));
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule